// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block follows the power state of a device core. The core may run in NORMAL or in one of three low-power states: IDLE, SLEEP and STOP. The block accepts a request to enter a low-power state, and it then watches the wake sources. These are a vector of maskable interrupt lines, a watchdog non-maskable interrupt, an external non-maskable interrupt pin and the reset pin. The block decides when one of them must end the low-power state.

The deeper the state, the fewer sources can end it. A maskable line may wake the device only if three things hold: its bit in a per-source eligibility table is set for the current state, its CPU-level enable is set, and, in SLEEP and STOP, its clock-generator wake-detect enable is set. The watchdog NMI ends only IDLE. The external NMI pin and the reset pin end any low-power state.

After an interrupt or NMI wake, the block issues a one-cycle request to start interrupt handling. For a level-sensitive line, this request is issued only if the line is still high. A wake by the reset pin returns the block to its initial state. If the device was in STOP, there is no automatic warm-up, so the block raises a flag telling the system to keep reset held until the oscillator is stable.

The state machine has five states:
- ST_NORMAL moves to ST_IDLE, ST_SLEEP or ST_STOP on an entry request.
- Each of the three low-power states moves to ST_PEND when an eligible event arrives.
- ST_PEND decides on the handling request and always returns to ST_NORMAL.
- The reset pin forces ST_NORMAL from any state.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: After rst_n is released, mode_o is 0 (NORMAL), and wake_o, wake_src_o, handle_req_o and warmup_hold_o are all 0.
- R2: In NORMAL, enter_req_i with enter_mode_i equal to 1 (IDLE), 2 (SLEEP) or 3 (STOP) sets mode_o to that value at the next clock. A request with enter_mode_i = 0 is ignored. Requests made in a low-power state, or in the cycle of a wake pulse, are also ignored.
- R3: Maskable line i ends low-power mode m only when all of the following hold:
  - irq_i[i] is high.
  - cpu_en_i[i] is high.
  - ELIG_MASK bit 3*i+0 is set for IDLE, bit 3*i+1 for SLEEP, or bit 3*i+2 for STOP.
  - For SLEEP and STOP only, cg_wake_en_i[i] is high.
- R4: ext_nmi_i ends IDLE, SLEEP and STOP. wdt_nmi_i ends IDLE only and has no effect in SLEEP or STOP.
- R5: If an eligible event is present in cycle t, then after the next clock mode_o is 0 and wake_o is high for one cycle. wake_src_o then carries the source code: i for line i, N_IRQ for the watchdog NMI, N_IRQ+1 for the external NMI and N_IRQ+2 for the reset pin. wake_src_o is 0 whenever wake_o is low.
- R6: When several events are eligible at once, the winner is chosen in this order: reset pin, then external NMI, then watchdog NMI, then the lowest-numbered eligible line.
- R7: handle_req_o is high for one cycle, in the cycle after a wake pulse, under either of two conditions:
  - the wake came from an NMI;
  - the waking line is still high during the wake-pulse cycle.
  If a maskable line has dropped by then, no handling request is issued.
- R8: pin_reset_i high returns mode_o to 0 at the next clock and cancels any pending handling request. If the block was in a low-power state, it gives a wake pulse with code N_IRQ+2.
- R9: warmup_hold_o rises at the clock after pin_reset_i is seen in STOP. It stays high while pin_reset_i stays high and falls at the clock after pin_reset_i goes low. A reset from any other state leaves it low.
- R10: An event present in the same cycle as an accepted entry request causes no wake in that cycle. It is evaluated against the new mode in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| enter_req_i | input | 1 | Request to enter a low-power state |
| enter_mode_i | input | 2 | Target state: 1 IDLE, 2 SLEEP, 3 STOP |
| irq_i | input | N_IRQ | Maskable interrupt request levels |
| cpu_en_i | input | N_IRQ | CPU-level interrupt enables |
| cg_wake_en_i | input | N_IRQ | Clock-generator wake-detect enables |
| wdt_nmi_i | input | 1 | Watchdog non-maskable interrupt |
| ext_nmi_i | input | 1 | External non-maskable interrupt pin |
| pin_reset_i | input | 1 | Synchronous reset pin |
| mode_o | output | 2 | Current state: 0 NORMAL, 1 IDLE, 2 SLEEP, 3 STOP |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_src_o | output | $clog2(N_IRQ+3) | Code of the waking source |
| handle_req_o | output | 1 | One-cycle request to start interrupt handling |
| warmup_hold_o | output | 1 | Keep reset held until the oscillator is stable |

## Verification
The assertions assume that every input is synchronous to clk and holds a defined value after reset. They also assume that enter_mode_i is meaningful only while enter_req_i is high. The level-drop check assumes that a waking line is sampled exactly once, in the wake-pulse cycle. The bench changes every input only on the falling edge. It clears all requests before each new entry, and it leaves each low-power state through a single external NMI pulse, so every pass starts from NORMAL.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_STOP   = 2'd3
    } mode_t;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_STOP   = 3'd3,
        ST_PEND   = 3'd4
    } state_t;

endpackage

// File: rtl/lpw_pick.sv
module lpw_pick
    import lpw_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter logic [3*N_IRQ-1:0] ELIG_MASK = '1,
    parameter int SRC_W = 3
) (
    input  mode_t              mode_i,
    input  logic [N_IRQ-1:0]   irq_i,
    input  logic [N_IRQ-1:0]   cpu_en_i,
    input  logic [N_IRQ-1:0]   cg_en_i,
    input  logic               wdt_nmi_i,
    input  logic               ext_nmi_i,
    output logic               hit_o,
    output logic [SRC_W-1:0]   src_o
);
    localparam int CODE_WDT = N_IRQ;
    localparam int CODE_EXT = N_IRQ + 1;

    logic [N_IRQ-1:0] elig;

    // per-line eligibility against the current low-power mode
    for (genvar g = 0; g < N_IRQ; g++) begin : g_elig
        logic in_idle, in_sleep, in_stop;
        assign in_idle  = (mode_i == MODE_IDLE)  & ELIG_MASK[3*g];
        assign in_sleep = (mode_i == MODE_SLEEP) & ELIG_MASK[3*g+1] & cg_en_i[g];
        assign in_stop  = (mode_i == MODE_STOP)  & ELIG_MASK[3*g+2] & cg_en_i[g];
        assign elig[g]  = irq_i[g] & cpu_en_i[g] & (in_idle | in_sleep | in_stop);
    end

    // later assignments carry higher priority
    always_comb begin
        hit_o = 1'b0;
        src_o = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit_o = 1'b1;
                src_o = SRC_W'(i);
            end
        end
        if (wdt_nmi_i && mode_i == MODE_IDLE) begin
            hit_o = 1'b1;
            src_o = SRC_W'(CODE_WDT);
        end
        if (ext_nmi_i && mode_i != MODE_NORMAL) begin
            hit_o = 1'b1;
            src_o = SRC_W'(CODE_EXT);
        end
    end

endmodule

// File: rtl/lpw_fsm.sv
module lpw_fsm
    import lpw_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int SRC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_req_i,
    input  mode_t              enter_mode_i,
    input  logic               pin_reset_i,
    input  logic [N_IRQ-1:0]   irq_i,
    input  logic               hit_i,
    input  logic [SRC_W-1:0]   src_i,
    output mode_t              mode_o,
    output logic               wake_o,
    output logic [SRC_W-1:0]   wake_src_o,
    output logic               handle_req_o,
    output logic               warmup_hold_o
);
    localparam int CODE_WDT = N_IRQ;
    localparam int CODE_RST = N_IRQ + 2;

    state_t           state_q, state_n;
    logic [SRC_W-1:0] psrc_q, psrc_n;
    logic             wake_n, hand_n, hold_n;
    logic [SRC_W-1:0] wsrc_n;
    logic             lvl;
    logic             in_lp;

    assign in_lp = (state_q == ST_IDLE) || (state_q == ST_SLEEP) || (state_q == ST_STOP);

    // level of the line that caused the pending wake
    always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (psrc_q == SRC_W'(i)) lvl = irq_i[i];
        end
    end

    // next-state and next-output logic
    always_comb begin
        state_n = state_q;
        psrc_n  = psrc_q;
        wake_n  = 1'b0;
        wsrc_n  = '0;
        hand_n  = 1'b0;
        hold_n  = pin_reset_i & (warmup_hold_o | (state_q == ST_STOP));
        if (pin_reset_i) begin
            state_n = ST_NORMAL;
            psrc_n  = '0;
            if (in_lp) begin
                wake_n = 1'b1;
                wsrc_n = SRC_W'(CODE_RST);
            end
        end else begin
            unique case (state_q)
                ST_NORMAL: begin
                    if (enter_req_i) begin
                        unique case (enter_mode_i)
                            MODE_NORMAL: state_n = ST_NORMAL;
                            MODE_IDLE:   state_n = ST_IDLE;
                            MODE_SLEEP:  state_n = ST_SLEEP;
                            MODE_STOP:   state_n = ST_STOP;
                        endcase
                    end
                end
                ST_IDLE, ST_SLEEP, ST_STOP: begin
                    if (hit_i) begin
                        state_n = ST_PEND;
                        psrc_n  = src_i;
                        wake_n  = 1'b1;
                        wsrc_n  = src_i;
                    end
                end
                ST_PEND: begin
                    state_n = ST_NORMAL;
                    hand_n  = (psrc_q >= SRC_W'(N_IRQ)) | lvl;
                    psrc_n  = '0;
                end
                default: state_n = ST_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            psrc_q  <= '0;
        end else begin
            state_q <= state_n;
            psrc_q  <= psrc_n;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_o        <= 1'b0;
            wake_src_o    <= '0;
            handle_req_o  <= 1'b0;
            warmup_hold_o <= 1'b0;
        end else begin
            wake_o        <= wake_n;
            wake_src_o    <= wsrc_n;
            handle_req_o  <= hand_n;
            warmup_hold_o <= hold_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  mode_o = MODE_IDLE;
            ST_SLEEP: mode_o = MODE_SLEEP;
            ST_STOP:  mode_o = MODE_STOP;
            default:  mode_o = MODE_NORMAL;
        endcase
    end

    assert_entry_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == MODE_NORMAL && mode_o != MODE_NORMAL) |-> $past(enter_req_i));

    assert_wake_from_lp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(mode_o) != MODE_NORMAL && mode_o == MODE_NORMAL));

    assert_wdt_idle_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && wake_src_o == SRC_W'(CODE_WDT)) |-> $past(mode_o) == MODE_IDLE);

    assert_handle_after_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handle_req_o |-> $past(wake_o));

    assert_reset_no_handle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && wake_src_o == SRC_W'(CODE_RST)) |=> !handle_req_o);

    assert_hold_from_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warmup_hold_o) |-> ($past(pin_reset_i) && $past(mode_o) == MODE_STOP));

endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter logic [3*N_IRQ-1:0] ELIG_MASK = 12'b110_001_011_111,
    localparam int SRC_W = $clog2(N_IRQ + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter_req_i,
    input  logic [1:0]         enter_mode_i,
    input  logic [N_IRQ-1:0]   irq_i,
    input  logic [N_IRQ-1:0]   cpu_en_i,
    input  logic [N_IRQ-1:0]   cg_wake_en_i,
    input  logic               wdt_nmi_i,
    input  logic               ext_nmi_i,
    input  logic               pin_reset_i,
    output logic [1:0]         mode_o,
    output logic               wake_o,
    output logic [SRC_W-1:0]   wake_src_o,
    output logic               handle_req_o,
    output logic               warmup_hold_o
);
    mode_t            cur_mode;
    logic             hit;
    logic [SRC_W-1:0] hit_src;

    lpw_pick #(.N_IRQ(N_IRQ), .ELIG_MASK(ELIG_MASK), .SRC_W(SRC_W)) pick_i (
        .mode_i    (cur_mode),
        .irq_i     (irq_i),
        .cpu_en_i  (cpu_en_i),
        .cg_en_i   (cg_wake_en_i),
        .wdt_nmi_i (wdt_nmi_i),
        .ext_nmi_i (ext_nmi_i),
        .hit_o     (hit),
        .src_o     (hit_src)
    );

    lpw_fsm #(.N_IRQ(N_IRQ), .SRC_W(SRC_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_req_i   (enter_req_i),
        .enter_mode_i  (mode_t'(enter_mode_i)),
        .pin_reset_i   (pin_reset_i),
        .irq_i         (irq_i),
        .hit_i         (hit),
        .src_i         (hit_src),
        .mode_o        (cur_mode),
        .wake_o        (wake_o),
        .wake_src_o    (wake_src_o),
        .handle_req_o  (handle_req_o),
        .warmup_hold_o (warmup_hold_o)
    );

    assign mode_o = cur_mode;

endmodule

// File: tb/lpw_wake_ctrl_tb.sv
module lpw_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam logic [3*N-1:0] MASK = 12'b110_001_011_111;
    localparam int SW = $clog2(N + 3);
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0;
    logic [1:0] enter_mode = 2'd0;
    logic [N-1:0] irq = '0, cpu_en = '0, cg_en = '0;
    logic wdt = 1'b0, ext = 1'b0, pin = 1'b0;
    logic [1:0] mode;
    logic wake, hand, hold;
    logic [SW-1:0] wsrc;

    int total = 0, bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // model state
    int m_mode = 0, m_psrc = 0, m_wake = 0, m_src = 0, m_hand = 0, m_hold = 0;
    bit m_pend = 1'b0;
    int n_mode, n_psrc, n_wake, n_src, n_hand, n_hold, pick;
    bit n_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpw_wake_ctrl #(.N_IRQ(N), .ELIG_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .enter_req_i(enter_req), .enter_mode_i(enter_mode),
        .irq_i(irq), .cpu_en_i(cpu_en), .cg_wake_en_i(cg_en), .wdt_nmi_i(wdt),
        .ext_nmi_i(ext), .pin_reset_i(pin), .mode_o(mode), .wake_o(wake),
        .wake_src_o(wsrc), .handle_req_o(hand), .warmup_hold_o(hold)
    );

    function automatic bit line_ok(int i, int md);
        return irq[i] && cpu_en[i] && MASK[3*i + md - 1] && (md == 1 || cg_en[i]);
    endfunction

    task automatic check(int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_psrc = 0; m_wake = 0; m_src = 0; m_hand = 0; m_hold = 0;
        end else begin
            n_mode = m_mode; n_pend = 0; n_psrc = m_psrc; n_wake = 0; n_src = 0; n_hand = 0;
            n_hold = (pin && (m_hold != 0 || m_mode == 3)) ? 1 : 0;
            if (pin) begin
                if (m_mode != 0) begin n_wake = 1; n_src = N + 2; end
                n_mode = 0; n_psrc = 0;
            end else if (m_pend) begin
                n_hand = (m_psrc >= N || irq[m_psrc]) ? 1 : 0;
                n_psrc = 0;
            end else if (m_mode == 0) begin
                if (enter_req && enter_mode != 0) n_mode = enter_mode;
            end else begin
                pick = -1;
                if (ext) pick = N + 1;
                else if (wdt && m_mode == 1) pick = N;
                else for (int i = 0; i < N; i++) if (pick < 0 && line_ok(i, m_mode)) pick = i;
                if (pick >= 0) begin
                    n_mode = 0; n_pend = 1; n_psrc = pick; n_wake = 1; n_src = pick;
                end
            end
            m_mode = n_mode; m_pend = n_pend; m_psrc = n_psrc; m_wake = n_wake;
            m_src = n_src; m_hand = n_hand; m_hold = n_hold;
        end
        #1;
        check(mode, m_mode, "mode_o");
        check(wake, m_wake, "wake_o");
        check(wsrc, m_src, "wake_src_o");
        check(hand, m_hand, "handle_req_o");
        check(hold, m_hold, "warmup_hold_o");
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet;
        enter_req = 0; irq = '0; wdt = 0; ext = 0; pin = 0;
    endtask

    task automatic enter(int md);
        enter_req = 1; enter_mode = 2'(md);
        @(negedge clk);
        enter_req = 0;
    endtask

    task automatic leave;
        ext = 1; cyc(1); ext = 0; cyc(4);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        tag = "R1";
        check(mode, 0, "reset mode_o"); check(wake, 0, "reset wake_o");
        check(hand, 0, "reset handle_req_o"); check(hold, 0, "reset warmup_hold_o");
        check(wsrc, 0, "reset wake_src_o");

        // every source in every mode, with and without clock-generator enables
        for (int md = 1; md <= 3; md++) begin
            for (int s = 0; s < N + 3; s++) begin
                for (int v = 0; v < 2; v++) begin
                    quiet;
                    cpu_en = '1;
                    cg_en = (v == 1) ? '1 : '0;
                    if (s < N) tag = "R3";
                    else if (s < N + 2) tag = "R4";
                    else tag = "R8 R9";
                    enter(md);
                    if (s < N) irq[s] = 1'b1;
                    else if (s == N) wdt = 1'b1;
                    else if (s == N + 1) ext = 1'b1;
                    else pin = 1'b1;
                    cyc(3);
                    quiet;
                    cyc(1);
                    leave;
                end
            end
        end

        // single wake and its timing
        tag = "R5";
        quiet; cpu_en = '1; cg_en = '1;
        enter(2); cyc(2); irq[0] = 1; cyc(3); quiet; cyc(3);

        // CPU enable low blocks a line
        tag = "R3";
        cpu_en = 4'b1110; enter(1); irq[0] = 1; cyc(3); quiet; leave; cpu_en = '1;

        // priority among simultaneous events
        tag = "R6";
        enter(1); irq = 4'b0110; wdt = 1; ext = 1; cyc(3); quiet; cyc(3);
        enter(1); irq = 4'b0110; wdt = 1; cyc(3); quiet; cyc(3);
        enter(1); irq = 4'b0110; cyc(3); quiet; cyc(3);
        enter(3); irq = 4'b1001; ext = 1; pin = 1; cyc(2); quiet; cyc(3);

        // level drop before handling starts
        tag = "R7";
        enter(1); irq[0] = 1; cyc(1); irq[0] = 0; cyc(4);
        enter(1); wdt = 1; cyc(1); wdt = 0; cyc(4);

        // entry requests that must be ignored
        tag = "R2";
        enter(0); cyc(2);
        enter(1); enter(3); cyc(2); leave;
        enter(1); irq[1] = 1; cyc(1); enter_req = 1; enter_mode = 2'd2; cyc(1);
        enter_req = 0; quiet; cyc(3);

        // event in the same cycle as the entry request
        tag = "R10";
        irq[0] = 1; enter(1); cyc(3); quiet; cyc(3);
        ext = 1; enter(2); ext = 0; cyc(4);

        // reset pin during a pending handling decision
        tag = "R8";
        enter(1); irq[0] = 1; cyc(1); pin = 1; cyc(1); quiet; cyc(3);

        // reset pin outside STOP leaves the hold flag low
        tag = "R9";
        enter(2); pin = 1; cyc(3); quiet; cyc(2);
        enter(3); pin = 1; cyc(5); quiet; cyc(3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog %s actual=running expected=finished", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule